// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Bridge

This block connects an internal request port with 32-bit addresses to external asynchronous SRAM or EEPROM devices over one shared 16-bit bus. The bus carries the address first and the data after it. Four fixed address windows are decoded, and each window owns one active-low chip-select line. An access presents the low address bits with a one-cycle latch strobe, so that an external transparent latch can hold them. A data phase then follows with a read or write strobe held for a fixed number of cycles. A hold cycle ends the access, and a one-cycle completion pulse goes back to the requester.

Each window is set independently to 16-bit or 8-bit memory. A 16-bit window reaches 64K halfwords and passes the byte enables to the high and low byte-enable pins. An 8-bit window reaches 128K bytes through an extra address line. A 16-bit request to an 8-bit window is broken into one byte access per enabled lane, with the low lane first. The requester holds its fields stable while it pulses `req_valid` for one cycle in an idle period. It then waits for `req_ready` before issuing anything else. Configuration inputs may change only between requests.

Top module: `xmb_bridge`

## Requirements
- R1: While `cfg_enable` is 0, a request completes in the cycle after it is accepted with `req_ready`=1 and `req_err`=1, and no select, latch or strobe pin moves.
- R2: Bits [31:16] of the address equal to 0x1000, 0x2000, 0x3000 or 0x4000 select window 0, 1, 2 or 3. During that access `mem_sel_n[i]` is driven low for the selected window i only, and at most one select is ever low.
- R3: A request fails with the same one-cycle error completion and no external activity in three cases: the address lies outside every window, the hit window has its `cfg_region_en` bit at 0, or `req_be` is 0.
- R4: The first cycle of every external access has `ale`=1 for exactly one cycle, the select low, both strobes high, and `bus_oe`=1. In that cycle `bus_out` holds the bus address.
- R5: The data phase keeps `rd_n` (read) or `wr_n` (write) low for WAIT_CYCLES cycles. A write drives its data with `bus_oe`=1. A read releases the bus (`bus_oe`=0) and returns the value of `bus_in` sampled in the last strobe cycle.
- R6: After the strobe rises, one hold cycle follows with the select still low. The select is then released in the same cycle as a one-cycle `req_ready` pulse with `req_err`=0.
- R7: In a 16-bit window the bus address is `req_addr[15:0]` and `a16`=0. The data uses all 16 bits, and during the data phase `bhe_n`=~`req_be[1]` and `ble_n`=~`req_be[0]`.
- R8: In an 8-bit window the byte address is {`req_addr[15:0]`, lane}, where the low byte is lane 0 and the high byte is lane 1. Bit 16 of the byte address goes out on `a16` and bits [15:0] on `bus_out`. Data travels on bus bits [7:0] with `ble_n`=0 and `bhe_n`=1.
- R9: An 8-bit window with both byte enables set performs two full accesses, lane 0 and then lane 1, with a single `req_ready` at the end. With one enable set it performs one access. Read bytes land in their lane of `req_rdata`, and lanes not read return 0. Writes return 0.
- R10: The width and enable of each window act only on that window. Changing one window leaves the behaviour of the others unchanged.
- R11: After reset all selects, strobes and byte enables are high, `ale`, `a16`, `bus_oe` and `req_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global enable of the external interface |
| cfg_region_en | input | NUM_REGIONS | Per-window enable |
| cfg_region_wide | input | NUM_REGIONS | Per-window width, 1 = 16-bit, 0 = 8-bit |
| req_valid | input | 1 | One-cycle request pulse, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Internal address |
| req_be | input | 2 | Byte enables, bit 1 high byte, bit 0 low byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Completion pulse |
| req_err | output | 1 | Error flag, valid with req_ready |
| req_rdata | output | 16 | Read data, valid with req_ready |
| bus_out | output | 16 | Address/data value driven onto the shared bus |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 16 | Value read from the shared bus |
| mem_sel_n | output | NUM_REGIONS | Active-low window selects |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bhe_n | output | 1 | Active-low high byte enable |
| ble_n | output | 1 | Active-low low byte enable |
| a16 | output | 1 | Extra address bit for 8-bit windows |

## Verification
The bound checker tests a set of pin rules on every cycle. At most one select is low. The latch strobe lasts a single cycle and occurs only with a select low and both strobes high. Read and write strobes never overlap, and the bus is never driven while reading. A hold cycle follows each strobe. An error completion comes with quiet pins, and `a16` is high only with the high byte enable off. Other behaviour shows only in the bench's scenarios, where a cycle-by-cycle reference model checks it: the exact bus address and data in each phase, the window decode, the length of the data phase, the order of the split byte accesses, how read bytes are merged, and how independent the windows are from one another.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } xmb_state_e;

  // Upper halfword of the base address of window idx: 0x1000, 0x2000, ...
  function automatic logic [15:0] window_tag(input int idx);
    return 16'((idx + 1) << 12);
  endfunction

endpackage

// File: rtl/xmb_decode.sv
module xmb_decode #(
  parameter int NUM_REGIONS = 4
) (
  input  logic [15:0]            addr_hi,
  input  logic [1:0]             be,
  input  logic                   glb_en,
  input  logic [NUM_REGIONS-1:0] region_en,
  input  logic [NUM_REGIONS-1:0] region_wide,
  output logic [NUM_REGIONS-1:0] hit,
  output logic                   wide,
  output logic                   bad
);

  logic [NUM_REGIONS-1:0] match;

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
      assign match[g] = (addr_hi == xmb_pkg::window_tag(g));
    end
  endgenerate

  always_comb begin
    hit  = match;
    wide = |(match & region_wide);
    bad  = !glb_en || !(|(match & region_en)) || (be == 2'b00);
  end

endmodule

// File: rtl/xmb_lane.sv
module xmb_lane (
  input  logic [1:0] be,
  input  logic       wide,
  output logic       first_lane,
  output logic       two_lanes
);

  // 16-bit windows always use lane 0 for the whole halfword.
  // 8-bit windows start with the low lane if enabled, else the high lane.
  always_comb begin
    first_lane = !wide && !be[0];
    two_lanes  = !wide && be[0] && be[1];
  end

endmodule

// File: rtl/xmb_seq.sv
module xmb_seq #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [15:0]            addr_lo,
  input  logic [1:0]             be,
  input  logic [15:0]            wdata,
  input  logic [15:0]            bus_in,
  input  logic [NUM_REGIONS-1:0] hit,
  input  logic                   wide,
  input  logic                   bad,
  input  logic                   first_lane,
  input  logic                   two_lanes,
  output logic                   req_ready,
  output logic                   req_err,
  output logic [15:0]            req_rdata,
  output logic [15:0]            bus_out,
  output logic                   bus_oe,
  output logic [NUM_REGIONS-1:0] mem_sel_n,
  output logic                   ale,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   bhe_n,
  output logic                   ble_n,
  output logic                   a16
);

  import xmb_pkg::*;

  localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYCLES - 1);

  xmb_state_e state;
  logic [CW-1:0] cnt;
  logic        wr_q, wide_q, lane_q, more_q;
  logic [15:0] addr_q, wdata_q;
  logic [1:0]  be_q;
  logic [15:0] lane_data;

  always_comb begin
    if (wide_q)      lane_data = wdata_q;
    else if (lane_q) lane_data = {8'h00, wdata_q[15:8]};
    else             lane_data = {8'h00, wdata_q[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      lane_q    <= 1'b0;
      more_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      req_ready <= 1'b0;
      req_err   <= 1'b0;
      req_rdata <= '0;
      bus_out   <= '0;
      bus_oe    <= 1'b0;
      mem_sel_n <= '1;
      ale       <= 1'b0;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      bhe_n     <= 1'b1;
      ble_n     <= 1'b1;
      a16       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          req_ready <= 1'b0;
          req_err   <= 1'b0;
          if (req_valid) begin
            req_rdata <= '0;
            if (bad) begin
              req_ready <= 1'b1;
              req_err   <= 1'b1;
            end else begin
              wr_q      <= req_write;
              wide_q    <= wide;
              lane_q    <= first_lane;
              more_q    <= two_lanes;
              addr_q    <= addr_lo;
              wdata_q   <= wdata;
              be_q      <= be;
              mem_sel_n <= ~hit;
              ale       <= 1'b1;
              bus_oe    <= 1'b1;
              bus_out   <= wide ? addr_lo : {addr_lo[14:0], first_lane};
              a16       <= wide ? 1'b0 : addr_lo[15];
              state     <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          ale     <= 1'b0;
          rd_n    <= wr_q;
          wr_n    <= !wr_q;
          bus_oe  <= wr_q;
          bus_out <= wr_q ? lane_data : 16'h0000;
          bhe_n   <= wide_q ? !be_q[1] : 1'b1;
          ble_n   <= wide_q ? !be_q[0] : 1'b0;
          cnt     <= CNT_LAST;
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt == '0) begin
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            bhe_n   <= 1'b1;
            ble_n   <= 1'b1;
            bus_oe  <= 1'b0;
            bus_out <= '0;
            if (!wr_q) begin
              if (wide_q)      req_rdata        <= bus_in;
              else if (lane_q) req_rdata[15:8]  <= bus_in[7:0];
              else             req_rdata[7:0]   <= bus_in[7:0];
            end
            state <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (more_q) begin
            more_q  <= 1'b0;
            lane_q  <= 1'b1;
            ale     <= 1'b1;
            bus_oe  <= 1'b1;
            bus_out <= {addr_q[14:0], 1'b1};
            a16     <= addr_q[15];
            state   <= ST_ADDR;
          end else begin
            mem_sel_n <= '1;
            a16       <= 1'b0;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xmb_bridge.sv
module xmb_bridge #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_enable,
  input  logic [NUM_REGIONS-1:0] cfg_region_en,
  input  logic [NUM_REGIONS-1:0] cfg_region_wide,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [31:0]            req_addr,
  input  logic [1:0]             req_be,
  input  logic [15:0]            req_wdata,
  output logic                   req_ready,
  output logic                   req_err,
  output logic [15:0]            req_rdata,
  output logic [15:0]            bus_out,
  output logic                   bus_oe,
  input  logic [15:0]            bus_in,
  output logic [NUM_REGIONS-1:0] mem_sel_n,
  output logic                   ale,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   bhe_n,
  output logic                   ble_n,
  output logic                   a16
);

  logic [NUM_REGIONS-1:0] hit;
  logic wide, bad, first_lane, two_lanes;

  xmb_decode #(.NUM_REGIONS(NUM_REGIONS)) u_decode (
    .addr_hi     (req_addr[31:16]),
    .be          (req_be),
    .glb_en      (cfg_enable),
    .region_en   (cfg_region_en),
    .region_wide (cfg_region_wide),
    .hit         (hit),
    .wide        (wide),
    .bad         (bad)
  );

  xmb_lane u_lane (
    .be         (req_be),
    .wide       (wide),
    .first_lane (first_lane),
    .two_lanes  (two_lanes)
  );

  xmb_seq #(.NUM_REGIONS(NUM_REGIONS), .WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .addr_lo    (req_addr[15:0]),
    .be         (req_be),
    .wdata      (req_wdata),
    .bus_in     (bus_in),
    .hit        (hit),
    .wide       (wide),
    .bad        (bad),
    .first_lane (first_lane),
    .two_lanes  (two_lanes),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .req_rdata  (req_rdata),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .mem_sel_n  (mem_sel_n),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bhe_n      (bhe_n),
    .ble_n      (ble_n),
    .a16        (a16)
  );

endmodule

// File: rtl/xmb_bridge_chk.sv
module xmb_bridge_chk #(
  parameter int NUM_REGIONS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_ready,
  input logic                   req_err,
  input logic                   bus_oe,
  input logic [NUM_REGIONS-1:0] mem_sel_n,
  input logic                   ale,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic                   bhe_n,
  input logic                   a16
);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_sel_n));

  p_ale_single_r4: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_ale_phase_r4: assert property (@(posedge clk) disable iff (rst)
    ale |-> (mem_sel_n != '1) && rd_n && wr_n && bus_oe);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    rd_n || wr_n);

  p_read_float_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe);

  p_hold_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> (mem_sel_n != '1) && !req_ready);

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_err) |-> (mem_sel_n == '1) && rd_n && wr_n && !ale);

  p_a16_byte_r8: assert property (@(posedge clk) disable iff (rst)
    a16 |-> bhe_n);

endmodule

bind xmb_bridge xmb_bridge_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .req_err   (req_err),
  .bus_oe    (bus_oe),
  .mem_sel_n (mem_sel_n),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .bhe_n     (bhe_n),
  .a16       (a16)
);

// File: tb/xmb_bridge_tb.sv
module xmb_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int WAITC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0;
  logic [NREG-1:0] cfg_region_en = '0;
  logic [NREG-1:0] cfg_region_wide = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, req_err, bus_oe, ale, rd_n, wr_n, bhe_n, ble_n, a16;
  logic [15:0] req_rdata, bus_out, bus_in;
  logic [NREG-1:0] mem_sel_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmb_bridge #(.NUM_REGIONS(NREG), .WAIT_CYCLES(WAITC)) u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_region_en(cfg_region_en),
    .cfg_region_wide(cfg_region_wide), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_err(req_err), .req_rdata(req_rdata), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .mem_sel_n(mem_sel_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .bhe_n(bhe_n), .ble_n(ble_n), .a16(a16)
  );

  typedef struct packed {
    logic [3:0]  sel;
    logic        ale, rd, wr, bhe, ble, a16, oe;
    logic [15:0] bus;
    logic        rdy, err;
    logic [15:0] rdata;
    logic [7:0]  tag;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int failures = 0;

  // External device model: the address is captured while ale is high.
  logic [16:0] lat_a = '0;
  logic [1:0]  lat_r = '0;

  function automatic logic [15:0] mem_fn(input logic [1:0] r, input logic [16:0] a);
    return a[15:0] ^ 16'h9C31 ^ {r, a[16], 13'h0};
  endfunction

  always @(posedge clk) begin
    if (ale) begin
      lat_a <= {a16, bus_out};
      for (int i = 0; i < NREG; i++) if (!mem_sel_n[i]) lat_r <= 2'(i);
    end
  end
  assign bus_in = mem_fn(lat_r, lat_a);

  function automatic exp_t idle_exp(input int tag);
    exp_t e;
    e = '0;
    e.sel = '1; e.rd = 1'b1; e.wr = 1'b1; e.bhe = 1'b1; e.ble = 1'b1;
    e.tag = 8'(tag);
    return e;
  endfunction

  task automatic check_cycle();
    exp_t e, a;
    logic bad;
    e = (expq.size() != 0) ? expq.pop_front() : idle_exp(11);
    a = '0;
    a.sel = mem_sel_n; a.ale = ale; a.rd = rd_n; a.wr = wr_n; a.bhe = bhe_n;
    a.ble = ble_n; a.a16 = a16; a.oe = bus_oe; a.rdy = req_ready; a.err = req_err;
    a.bus = e.oe ? bus_out : 16'h0;
    a.rdata = e.rdy ? req_rdata : 16'h0;
    a.tag = e.tag;
    bad = (a !== e);
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL R%0d t=%0t actual=%h expected=%h", e.tag, $time, a, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_cycle();
  endtask

  // One external access (one halfword or one byte lane).
  task automatic push_access(input int r, input logic wide, input logic wr,
                             input logic [15:0] a, input logic lane,
                             input logic [1:0] be, input logic [15:0] wd, input int tag);
    exp_t e;
    logic [3:0] sel;
    sel = ~(4'b1 << r);
    e = idle_exp(tag);
    e.sel = sel; e.ale = 1'b1; e.oe = 1'b1;
    e.bus = wide ? a : {a[14:0], lane};
    e.a16 = wide ? 1'b0 : a[15];
    expq.push_back(e);
    for (int k = 0; k < WAITC; k++) begin
      e = idle_exp(tag);
      e.sel = sel; e.a16 = wide ? 1'b0 : a[15];
      e.rd = wr; e.wr = !wr; e.oe = wr;
      e.bhe = wide ? !be[1] : 1'b1;
      e.ble = wide ? !be[0] : 1'b0;
      e.bus = wr ? (wide ? wd : {8'h00, lane ? wd[15:8] : wd[7:0]}) : 16'h0;
      expq.push_back(e);
    end
    e = idle_exp(tag);
    e.sel = sel; e.a16 = wide ? 1'b0 : a[15];
    expq.push_back(e);
  endtask

  task automatic request(input logic wr, input logic [31:0] addr, input logic [1:0] be,
                         input logic [15:0] wd, input int tag);
    int r;
    logic bad, wide;
    logic [15:0] rd;
    exp_t e;
    r = -1;
    for (int i = 0; i < NREG; i++) if (addr[31:16] == 16'((i + 1) * 16'h1000)) r = i;
    bad = !cfg_enable || (r < 0) || (be == 2'b00);
    if (!bad) bad = !cfg_region_en[r];
    wide = bad ? 1'b0 : cfg_region_wide[r];
    rd = 16'h0;
    if (bad) begin
      e = idle_exp(tag); e.rdy = 1'b1; e.err = 1'b1; e.rdata = 16'h0;
      expq.push_back(e);
    end else begin
      if (wide) begin
        push_access(r, 1'b1, wr, addr[15:0], 1'b0, be, wd, tag);
        if (!wr) rd = mem_fn(2'(r), {1'b0, addr[15:0]});
      end else begin
        for (int ln = 0; ln < 2; ln++) begin
          if (be[ln]) begin
            push_access(r, 1'b0, wr, addr[15:0], ln[0], be, wd, tag);
            if (!wr) begin
              if (ln == 0) rd[7:0]  = mem_fn(2'(r), {addr[15:0], 1'b0})[7:0];
              else         rd[15:8] = mem_fn(2'(r), {addr[15:0], 1'b1})[7:0];
            end
          end
        end
      end
      e = idle_exp(tag); e.rdy = 1'b1; e.rdata = rd;
      expq.push_back(e);
    end
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    step();
    req_valid = 1'b0;
    while (expq.size() != 0) step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: idle pin state after reset
    repeat (3) step();

    // R1: global enable off
    cfg_region_en = 4'hF; cfg_region_wide = 4'b0101;
    request(1'b0, 32'h1000_0010, 2'b11, 16'h0, 1);
    request(1'b1, 32'h2000_0010, 2'b01, 16'h1234, 1);

    cfg_enable = 1'b1;
    // R4 R5 R7: 16-bit window 0, full and partial byte enables
    request(1'b1, 32'h1000_ABCD, 2'b11, 16'hBEEF, 7);
    request(1'b0, 32'h1000_1234, 2'b11, 16'h0, 5);
    request(1'b1, 32'h1000_0F0F, 2'b10, 16'hC3A5, 7);
    request(1'b0, 32'h1000_0002, 2'b01, 16'h0, 7);
    // R2: window 2 (16-bit), R6 hold then completion
    request(1'b0, 32'h3000_7777, 2'b11, 16'h0, 2);
    request(1'b1, 32'h3000_0001, 2'b11, 16'h5A5A, 6);
    // R8 R9: 8-bit window 1 split accesses, a16 from byte address
    request(1'b1, 32'h2000_8421, 2'b11, 16'hA1B2, 9);
    request(1'b0, 32'h2000_8421, 2'b11, 16'h0, 9);
    request(1'b0, 32'h2000_0100, 2'b10, 16'h0, 9);
    request(1'b1, 32'h2000_FFFF, 2'b01, 16'h00C7, 8);
    // R2 R8: 8-bit window 3
    request(1'b0, 32'h4000_C001, 2'b01, 16'h0, 8);
    // R3: outside windows, just past a window, zero byte enables
    request(1'b0, 32'h5000_0000, 2'b11, 16'h0, 3);
    request(1'b0, 32'h1001_0000, 2'b11, 16'h0, 3);
    request(1'b0, 32'h0000_0010, 2'b11, 16'h0, 3);
    request(1'b1, 32'h1000_0004, 2'b00, 16'h1111, 3);
    // R10: disable window 2 only, others unchanged
    cfg_region_en = 4'b1011;
    request(1'b0, 32'h3000_0040, 2'b11, 16'h0, 10);
    request(1'b0, 32'h1000_0040, 2'b11, 16'h0, 10);
    request(1'b0, 32'h4000_0040, 2'b11, 16'h0, 10);
    // R10: window 0 switched to 8-bit, window 2 re-enabled stays 16-bit
    cfg_region_wide = 4'b0100; cfg_region_en = 4'hF;
    request(1'b0, 32'h1000_9001, 2'b11, 16'h0, 10);
    request(1'b0, 32'h3000_9001, 2'b11, 16'h0, 10);

    repeat (2) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule